// File: doc/BRIEF.md
# Hierarchical Scan-Out Merge Tree

This block returns the value of one addressed storage cell from a large grid of test-accessible cells to a single output pin pair. Every cell presents a data bit and a select bit; the select bit comes from an address decoder outside this block and is high only for the cell being read. The cells are merged four at a time by small merge cells. Each merge cell passes on the data of its active source, plus a combined "one of mine is selected" bit. These merge cells are cascaded level by level until one data bit and one valid bit remain at the root.

The leaf level groups sixteen cells (a 4×4 tile of the grid) under four merge cells, and each higher level merges four lower merge cells. A compile-time option places a register on both outputs of every merge cell. The read path then becomes a pipeline whose latency equals the number of tree levels, and it can accept a new address every cycle. Without the option the path is purely combinational. When the cell count is not a power of four, the missing tree inputs are tied inactive.

Top module: `scanout_tree`

## Requirements
- R1: `root_valid` is high exactly when at least one bit of `cell_sel` was high in the input cycle that the output corresponds to.
- R2: When exactly one bit `cell_sel[i]` is high, `root_data` equals `cell_data[i]`, whatever the data bits of all other cells are.
- R3: When no `cell_sel` bit is high, `root_valid` is 0 and `root_data` is 0, even when every `cell_data` bit is 1.
- R4: When several `cell_sel` bits are high, the data of the lowest-numbered selected cell is returned.
- R5: With `PIPELINE=1` the output for an input vector appears exactly `LEVELS` clock edges after it is applied, where `LEVELS` is ceil(log4 `N_CELLS`) and is at least 1 (3 for 64 cells). With `PIPELINE=0` it appears in the same cycle, with no clock edge.
- R6: With `PIPELINE=1`, a rising clock edge sampled with `rst_n` low clears every merge register, so both root outputs read 0 after that edge.
- R7: For a cell count that is not a power of four (for example 20 cells in a 64-input tree), every real cell, including the last tile, reads out correctly, and the padded tree inputs never raise `root_valid`.
- R8: With `PIPELINE=1`, vectors applied on consecutive cycles come out on consecutive cycles, in order, without loss or mixing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional merge registers |
| rst_n | input | 1 | Synchronous active-low reset of the merge registers |
| cell_data | input | N_CELLS | Current value of every grid cell; bit i is cell i |
| cell_sel | input | N_CELLS | Decoded select per cell; bit i high addresses cell i |
| root_data | output | 1 | Data of the addressed cell, at the tree root |
| root_valid | output | 1 | High when some cell was addressed |

## Verification
The hardest situation to reach is a wrong source whose data happens to match the right one. To rule it out, every addressed read drives all the other cells to the opposite value of the addressed cell, for both polarities and for every cell. Reads are also streamed back to back with the address changing every cycle, so a stage that is off by one cycle or leaks between neighbours shows up as a wrong bit. A second, combinational instance with 20 cells exercises the padded edge of the tree. It also runs deliberate two-hot selects to pin down the lowest-index priority.

// File: rtl/scanout_pkg.sv
// Package: shared sizing helpers for the scan-out merge tree.
// Assumes every count passed in is at least 1.
package scanout_pkg;

    // Purpose: 4 to the power e.
    function automatic int pow4(input int e);
        int r;
        r = 1;
        for (int k = 0; k < e; k++) r = r * 4;
        return r;
    endfunction

    // Purpose: number of 4-to-1 levels needed for n leaves (at least one).
    function automatic int clog4(input int n);
        int lv;
        int span;
        lv = 1;
        span = 4;
        while (span < n) begin
            span = span * 4;
            lv = lv + 1;
        end
        return lv;
    endfunction

    // Purpose: offset of level k in the flat node bus (level 0 = padded leaves).
    function automatic int level_base(input int levels, input int k);
        int b;
        b = 0;
        for (int j = 0; j < k; j++) b = b + pow4(levels - j);
        return b;
    endfunction

    // Purpose: total node count over all levels, root included.
    function automatic int node_total(input int levels);
        return level_base(levels, levels + 1);
    endfunction

endpackage

// File: rtl/scanout_merge4.sv
// Module: one 4-to-1 merge cell of the scan-out tree.
// Forwards the data of the selected source and the OR of the four selects.
// If several selects are high, the lowest index wins; with none high the
// data output is 0. REGISTERED=1 puts a flop on both outputs.
// Assumes: synchronous active-low reset; clk/rst_n are unused when REGISTERED=0.
module scanout_merge4 #(
    parameter bit REGISTERED = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src_data,
    input  logic [3:0] src_sel,
    output logic       out_data,
    output logic       out_sel
);

    logic m_data;
    logic m_sel;

    // Purpose: priority merge of the four sources, lowest index first.
    always_comb begin
        m_sel  = |src_sel;
        m_data = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            if (src_sel[i]) m_data = src_data[i];
        end
    end

    generate
        if (REGISTERED) begin : g_reg
            // Purpose: pipeline stage on both outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_data <= 1'b0;
                    out_sel  <= 1'b0;
                end else begin
                    out_data <= m_data;
                    out_sel  <= m_sel;
                end
            end
        end else begin : g_comb
            assign out_data = m_data;
            assign out_sel  = m_sel;
        end
    endgenerate

endmodule

// File: rtl/scanout_level.sv
// Module: one level of the merge tree, a row of NODES merge cells.
// Input bits 4n..4n+3 feed node n. Assumes NODES >= 1.
module scanout_level #(
    parameter int NODES      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4*NODES-1:0] in_data,
    input  logic [4*NODES-1:0] in_sel,
    output logic [NODES-1:0]   out_data,
    output logic [NODES-1:0]   out_sel
);

    generate
        for (genvar n = 0; n < NODES; n++) begin : g_node
            scanout_merge4 #(
                .REGISTERED(REGISTERED)
            ) u_merge (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_data (in_data[4*n +: 4]),
                .src_sel  (in_sel[4*n +: 4]),
                .out_data (out_data[n]),
                .out_sel  (out_sel[n])
            );
        end
    endgenerate

endmodule

// File: rtl/scanout_tree.sv
// Module: top of the hierarchical scan-out tree.
// Pads the cell inputs to a power of four (padding is select 0, data 0),
// then reduces them through LEVELS rows of 4-to-1 merge cells.
// All levels share one flat node bus: level k starts at level_base(LEVELS,k),
// and the root is its last bit.
// Assumes the external decoder raises at most one cell_sel bit at a time.
module scanout_tree
    import scanout_pkg::*;
#(
    parameter int N_CELLS  = 64,
    parameter bit PIPELINE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] cell_data,
    input  logic [N_CELLS-1:0] cell_sel,
    output logic               root_data,
    output logic               root_valid
);

    localparam int LEVELS = clog4(N_CELLS);
    localparam int PADDED = pow4(LEVELS);
    localparam int TOTAL  = node_total(LEVELS);

    logic [TOTAL-1:0] node_data;
    logic [TOTAL-1:0] node_sel;

    generate
        // Level 0: real cells, plus inactive padding when needed.
        if (PADDED > N_CELLS) begin : g_pad
            assign node_data[PADDED-1:0] = {{(PADDED-N_CELLS){1'b0}}, cell_data};
            assign node_sel[PADDED-1:0]  = {{(PADDED-N_CELLS){1'b0}}, cell_sel};
        end else begin : g_nopad
            assign node_data[PADDED-1:0] = cell_data;
            assign node_sel[PADDED-1:0]  = cell_sel;
        end

        for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
            localparam int IN_BASE  = level_base(LEVELS, lv);
            localparam int OUT_BASE = level_base(LEVELS, lv + 1);
            localparam int NODES    = pow4(LEVELS - lv - 1);

            scanout_level #(
                .NODES      (NODES),
                .REGISTERED (PIPELINE)
            ) u_level (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_data  (node_data[IN_BASE +: 4*NODES]),
                .in_sel   (node_sel[IN_BASE +: 4*NODES]),
                .out_data (node_data[OUT_BASE +: NODES]),
                .out_sel  (node_sel[OUT_BASE +: NODES])
            );
        end
    endgenerate

    assign root_data  = node_data[TOTAL-1];
    assign root_valid = node_sel[TOTAL-1];

endmodule

// File: rtl/scanout_tree_chk.sv
// Module: assertion checker for scanout_tree, bound to every instance.
// Keeps a port-level reference (OR of selects, lowest-index data) delayed by
// LEVELS cycles in pipelined mode, and compares the root outputs with it.
module scanout_tree_chk #(
    parameter int N_CELLS  = 64,
    parameter bit PIPELINE = 1'b1,
    parameter int LEVELS   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CELLS-1:0] cell_data,
    input logic [N_CELLS-1:0] cell_sel,
    input logic               root_data,
    input logic               root_valid
);

    logic ref_any;
    logic ref_dat;

    // Purpose: reference read result of the current inputs.
    always_comb begin
        ref_any = |cell_sel;
        ref_dat = 1'b0;
        for (int i = N_CELLS - 1; i >= 0; i--) begin
            if (cell_sel[i]) ref_dat = cell_data[i];
        end
    end

    // R3: an idle root never carries a 1.
    a_r3_idle_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        !root_valid |-> !root_data);

    generate
        if (PIPELINE) begin : g_pipe
            logic [LEVELS-1:0] h_any;
            logic [LEVELS-1:0] h_dat;
            logic rst_q   = 1'b1;
            logic started = 1'b0;

            // Purpose: delay line of the reference, one stage per tree level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    h_any <= '0;
                    h_dat <= '0;
                end else begin
                    h_any[0] <= ref_any;
                    h_dat[0] <= ref_dat;
                    for (int k = 1; k < LEVELS; k++) begin
                        h_any[k] <= h_any[k-1];
                        h_dat[k] <= h_dat[k-1];
                    end
                end
            end

            // R1, R5, R8: valid appears exactly LEVELS cycles later.
            a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
                root_valid == h_any[LEVELS-1]);

            // R2, R4, R5, R8: data of the lowest selected cell, LEVELS cycles later.
            a_r2_data_latency: assert property (@(posedge clk) disable iff (!rst_n)
                root_data == h_dat[LEVELS-1]);

            // Purpose: R6, outputs are clear after an edge with reset low.
            always_ff @(posedge clk) begin
                started <= 1'b1;
                rst_q   <= rst_n;
                if (started && !rst_q) begin
                    a_r6_reset_clears: assert (!root_valid && !root_data);
                end
            end
        end else begin : g_comb
            // R5: combinational mode answers in the same cycle.
            a_r5_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
                root_valid == ref_any);
            a_r5_comb_data: assert property (@(posedge clk) disable iff (!rst_n)
                root_data == ref_dat);
        end
    endgenerate

endmodule

bind scanout_tree scanout_tree_chk #(
    .N_CELLS  (N_CELLS),
    .PIPELINE (PIPELINE),
    .LEVELS   (LEVELS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_data  (cell_data),
    .cell_sel   (cell_sel),
    .root_data  (root_data),
    .root_valid (root_valid)
);

// File: tb/scanout_tree_bench.sv
`timescale 1ns/1ps
// Bench: a pipelined 64-cell tree and a combinational 20-cell tree.
// Expected values come from the select/data vectors alone.
module scanout_tree_bench;

    localparam int N   = 64;
    localparam int LAT = 3;
    localparam int NF  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]  sel = '0;
    logic [N-1:0]  dat = '0;
    logic [NF-1:0] fsel = '0;
    logic [NF-1:0] fdat = '0;
    logic root_data, root_valid;
    logic f_data, f_valid;

    int checks = 0;
    int fails  = 0;

    logic  hv [0:LAT-1];
    logic  hd [0:LAT-1];
    string ht [0:LAT-1];

    always #2.5 clk = ~clk;

    scanout_tree #(.N_CELLS(N), .PIPELINE(1'b1)) u_scanout_tree (
        .clk(clk), .rst_n(rst_n), .cell_data(dat), .cell_sel(sel),
        .root_data(root_data), .root_valid(root_valid));

    scanout_tree #(.N_CELLS(NF), .PIPELINE(1'b0)) u_scanout_tree_flat (
        .clk(clk), .rst_n(rst_n), .cell_data(fdat), .cell_sel(fsel),
        .root_data(f_data), .root_valid(f_valid));

    function automatic logic ref_v(input logic [N-1:0] s);
        return |s;
    endfunction

    function automatic logic ref_d(input logic [N-1:0] s, input logic [N-1:0] d);
        for (int i = 0; i < N; i++) if (s[i]) return d[i];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_hist(input string tag);
        for (int k = 0; k < LAT; k++) begin
            hv[k] = 1'b0; hd[k] = 1'b0; ht[k] = tag;
        end
    endtask

    // One pipelined cycle: check the vector from LAT cycles ago, apply a new one.
    task automatic pstep(input logic [N-1:0] s, input logic [N-1:0] d, input string tag);
        @(negedge clk);
        check({ht[LAT-1], " valid"}, root_valid, hv[LAT-1]);
        check({ht[LAT-1], " data"},  root_data,  hd[LAT-1]);
        for (int k = LAT - 1; k > 0; k--) begin
            hv[k] = hv[k-1]; hd[k] = hd[k-1]; ht[k] = ht[k-1];
        end
        hv[0] = ref_v(s); hd[0] = ref_d(s, d); ht[0] = tag;
        sel = s; dat = d;
    endtask

    task automatic fstep(input logic [NF-1:0] s, input logic [NF-1:0] d, input string tag);
        @(negedge clk);
        fsel = s; fdat = d;
        #1;
        check({tag, " flat valid"}, f_valid, ref_v(N'(s)));
        check({tag, " flat data"},  f_data,  ref_d(N'(s), N'(d)));
    endtask

    // R6: reset while reads are in flight.
    task automatic do_reset;
        @(negedge clk);
        sel = '0; dat = '0; rst_n = 1'b0;
        @(negedge clk);
        check("R6 reset valid", root_valid, 1'b0);
        check("R6 reset data",  root_data,  1'b0);
        rst_n = 1'b1;
        clear_hist("R6");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_hist("R6");
        repeat (3) @(negedge clk);
        check("R6 initial valid", root_valid, 1'b0);
        check("R6 initial data",  root_data,  1'b0);
        rst_n = 1'b1;

        // R3: idle with all data ones.
        for (int k = 0; k < 4; k++) pstep('0, '1, "R3");

        // R2 / R1 / R8: every cell, both polarities, back to back, others opposite.
        for (int i = 0; i < N; i++) begin
            for (int b = 0; b < 2; b++) begin
                logic [N-1:0] one;
                one = N'(1) << i;
                pstep(one, b[0] ? one : ~one, "R2");
            end
        end

        // R5: isolated reads, output must show exactly LAT edges later.
        for (int i = 0; i < N; i += 21) begin
            logic [N-1:0] one;
            one = N'(1) << i;
            pstep(one, one, "R5");
            for (int k = 0; k < LAT; k++) pstep('0, '1, "R5");
        end

        // R4: two-hot selects, lower index wins.
        for (int i = 0; i < N - 1; i += 7) begin
            for (int b = 0; b < 2; b++) begin
                logic [N-1:0] s2;
                logic [N-1:0] d2;
                s2 = (N'(1) << i) | (N'(1) << (N - 1 - i / 2));
                d2 = b[0] ? (N'(1) << i) : ~(N'(1) << i);
                pstep(s2, d2, "R4");
            end
        end

        // R8: alternating ones and idles every cycle.
        for (int k = 0; k < 16; k++) begin
            logic [N-1:0] one;
            one = N'(1) << (k * 4 + 1);
            pstep(k[0] ? '0 : one, k[1] ? one : '0, "R8");
        end

        // R6: reset in flight, then resume.
        pstep(N'(1) << 5, '1, "R6");
        pstep(N'(1) << 9, '1, "R6");
        do_reset();
        for (int k = 0; k < 4; k++) pstep('0, '1, "R6");
        pstep(N'(1) << 63, N'(1) << 63, "R8");
        for (int k = 0; k < LAT + 1; k++) pstep('0, '0, "R3");

        // R5 / R7: combinational 20-cell tree, full sweep including padded edge.
        for (int i = 0; i < NF; i++) begin
            for (int b = 0; b < 2; b++) begin
                logic [NF-1:0] one;
                one = NF'(1) << i;
                fstep(one, b[0] ? one : ~one, (i >= 16) ? "R7" : "R5");
            end
        end
        fstep('0, '1, "R7");
        fstep('0, '0, "R3");
        fstep(NF'(1) << 19 | NF'(1) << 16, NF'(1) << 16, "R4");
        fstep(NF'(1) << 19 | NF'(1) << 16, NF'(1) << 19, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule